// File: doc/BRIEF.md
# Interrupt Mask and Clear Controller

This block keeps the interrupt state behind one device-to-host interrupt line. Internal event pulses from the upstream event source set an internal pending flag. A memory-mapped control register, written through a simple strobe-and-data port, decides whether that pending flag reaches the external interrupt output. The pending flag and the output level are both exposed for readback.

Masking and clearing act on different state. Setting the mask freezes the output where it is and leaves pending state alone. A clear removes pending state, but while the mask is set the output keeps its level until the mask is lifted. A separate hold mode forces the output low and protects the pending flag from clears. When tagging is enabled, every event advances an 8-bit status tag. Software compares successive tags to detect that a new status update happened.

Top module: `irq_mask_ctl`

## Requirements
- R1: The control register holds bit 1 = mask, bit 2 = hold, bit 3 = tag enable and bit 0 = clear. Each write replaces all fields. Readback returns the stored mask, hold and tag-enable bits in those positions. Bit 0 always reads 0.
- R2: After reset the output, the pending flag, the tag and the control readback are all 0.
- R3: With mask and hold both 0, an event sets the pending flag and the output at the next clock edge.
- R4: While the mask is set, events set the pending flag but never raise the output.
- R5: Setting the mask changes neither an asserted output nor the pending flag.
- R6: A clear written with mask and hold both 0 deasserts the output and the pending flag at the next edge.
- R7: A clear written while masked clears the pending flag and keeps the output asserted. A later unmask then deasserts the output.
- R8: When a write leaves the block unmasked, the output takes the value of the pending flag at the next edge. So an unmask with pending set asserts the output one edge later.
- R9: An event in the same cycle as a clear write wins: the pending flag is set afterwards.
- R10: While hold is set, the output is 0 and clear writes leave the pending flag untouched. Releasing hold with the mask at 0 sets the output equal to the pending flag.
- R11: With tag enable set, each event advances the tag by one, going from 255 to 1 so the tag never returns to 0. With tag enable at 0, the tag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Interrupt event pulse, one per cycle high |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data (bit 0 clear, bit 1 mask, bit 2 hold, bit 3 tag enable) |
| ctl_rdata_o | output | 4 | Control readback; bit 0 reads 0 |
| pend_o | output | 1 | Internal pending flag |
| irq_o | output | 1 | External interrupt output level |
| tag_o | output | TAG_W (8) | Status tag |

## Verification
The hardest state to reach is the split where the output is still asserted but the pending flag is already clear. The stimulus gets there in three steps: an event raises the output while unmasked, a mask write follows, and then a clear is written with the mask bit kept set. The following unmask must then drop the output. The vector table also covers the case where an event and a clear land in the same cycle, and a clear issued during hold. A directed run of more than 256 tagged events drives the tag through its wrap so that the skip over 0 is observed.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    // Control word layout; positions are decoded by software.
    localparam int unsigned CTL_W    = 4;
    localparam int unsigned CLR_BIT  = 0;
    localparam int unsigned MASK_BIT = 1;
    localparam int unsigned HOLD_BIT = 2;
    localparam int unsigned TAG_BIT  = 3;

    typedef struct packed {
        logic tag_en;
        logic hold;
        logic mask;
    } ctl_t;

    typedef struct packed {
        logic pend;
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output ctl_t             ctl_n_o,
    output ctl_t             ctl_q_o,
    output logic             clr_o
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we_i) begin
            ctl_d.mask   = wdata_i[MASK_BIT];
            ctl_d.hold   = wdata_i[HOLD_BIT];
            ctl_d.tag_en = wdata_i[TAG_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign ctl_n_o = ctl_d;
    assign ctl_q_o = ctl_q;
    assign clr_o   = we_i & wdata_i[CLR_BIT];
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
    import irq_ctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic clr_i,
    input  ctl_t ctl_n_i,
    output logic pend_o,
    output logic irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear is ignored under hold; a same-cycle event always wins
        st_d.pend = evt_i | (st_q.pend & ~(clr_i & ~ctl_n_i.hold));
        if (ctl_n_i.hold)      st_d.irq = 1'b0;
        else if (ctl_n_i.mask) st_d.irq = st_q.irq;
        else                   st_d.irq = st_d.pend;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/irq_tag_gen.sv
module irq_tag_gen #(
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             en_i,
    output logic [TAG_W-1:0] tag_o
);
    localparam logic [TAG_W-1:0] TAG_MAX = '1;
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

    logic [TAG_W-1:0] tag_d, tag_q;

    always_comb begin
        tag_d = tag_q;
        if (en_i && evt_i) begin
            tag_d = (tag_q == TAG_MAX) ? TAG_ONE : tag_q + TAG_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tag_q <= '0;
        else         tag_q <= tag_d;
    end

    assign tag_o = tag_q;
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic [CTL_W-1:0] ctl_rdata_o,
    output logic             pend_o,
    output logic             irq_o,
    output logic [TAG_W-1:0] tag_o
);
    ctl_t ctl_n, ctl_q;
    logic clr;

    irq_ctl_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .ctl_n_o (ctl_n),
        .ctl_q_o (ctl_q),
        .clr_o   (clr)
    );

    irq_pend_core u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (evt_i),
        .clr_i   (clr),
        .ctl_n_i (ctl_n),
        .pend_o  (pend_o),
        .irq_o   (irq_o)
    );

    irq_tag_gen #(.TAG_W(TAG_W)) u_tag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .en_i   (ctl_n.tag_en),
        .tag_o  (tag_o)
    );

    always_comb begin
        ctl_rdata_o           = '0;
        ctl_rdata_o[MASK_BIT] = ctl_q.mask;
        ctl_rdata_o[HOLD_BIT] = ctl_q.hold;
        ctl_rdata_o[TAG_BIT]  = ctl_q.tag_en;
    end
endmodule

// File: rtl/irq_mask_ctl_chk.sv
module irq_mask_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int unsigned TAG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             evt_i,
    input logic             ctl_we_i,
    input logic [CTL_W-1:0] ctl_wdata_i,
    input logic [CTL_W-1:0] ctl_rdata_o,
    input logic             pend_o,
    input logic             irq_o,
    input logic [TAG_W-1:0] tag_o
);
    assert_masked_no_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && ctl_rdata_o[MASK_BIT] && !(ctl_we_i && !ctl_wdata_i[MASK_BIT]))
        |=> !irq_o);

    assert_mask_keeps_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && ctl_rdata_o[MASK_BIT] &&
         !(ctl_we_i && (!ctl_wdata_i[MASK_BIT] || ctl_wdata_i[HOLD_BIT])))
        |=> irq_o);

    assert_clear_unmasked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_we_i && ctl_wdata_i[CLR_BIT] && !ctl_wdata_i[MASK_BIT] &&
         !ctl_wdata_i[HOLD_BIT] && !evt_i)
        |=> (!irq_o && !pend_o));

    assert_unmasked_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctl_rdata_o[MASK_BIT] && !ctl_rdata_o[HOLD_BIT]) |-> (irq_o == pend_o));

    assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> pend_o);

    assert_hold_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_rdata_o[HOLD_BIT] |-> !irq_o);

    assert_tag_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tag_o != '0) |=> (tag_o != '0));
endmodule

bind irq_mask_ctl irq_mask_ctl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .ctl_rdata_o (ctl_rdata_o),
    .pend_o      (pend_o),
    .irq_o       (irq_o),
    .tag_o       (tag_o)
);

// File: tb/irq_mask_ctl_tb.sv
module irq_mask_ctl_tb;
    localparam int TAG_W = 8;
    localparam int NV    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt = 1'b0;
    logic             we = 1'b0;
    logic [3:0]       wd = '0;
    logic [3:0]       rd;
    logic             pend, irq;
    logic [TAG_W-1:0] tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_mask_ctl #(.TAG_W(TAG_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ctl_we_i(we),
        .ctl_wdata_i(wd), .ctl_rdata_o(rd), .pend_o(pend), .irq_o(irq), .tag_o(tag)
    );

    // {we, wdata[3:0], evt, exp irq, exp pend, exp rdata[3:0], exp tag[7:0]}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 8'd0},  // R3 unmasked event
        {1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd0},  // R6 clear, R1 bit0 reads 0
        {1'b1, 4'b0010, 1'b1, 1'b0, 1'b1, 4'b0010, 8'd0},  // R4 masked event
        {1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0010, 8'd0},  // R4 still low
        {1'b1, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 8'd0},  // R8 unmask with pending
        {1'b1, 4'b0010, 1'b0, 1'b1, 1'b1, 4'b0010, 8'd0},  // R5 mask keeps level
        {1'b1, 4'b0011, 1'b0, 1'b1, 1'b0, 4'b0010, 8'd0},  // R7 clear while masked
        {1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd0},  // R7 unmask drops output
        {1'b1, 4'b0001, 1'b1, 1'b1, 1'b1, 4'b0000, 8'd0},  // R9 event beats clear
        {1'b1, 4'b0100, 1'b0, 1'b0, 1'b1, 4'b0100, 8'd0},  // R10 hold forces low
        {1'b1, 4'b0101, 1'b0, 1'b0, 1'b1, 4'b0100, 8'd0},  // R10 clear ignored
        {1'b1, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 8'd0},  // R10 release
        {1'b1, 4'b1000, 1'b1, 1'b1, 1'b1, 4'b1000, 8'd1},  // R11 first tag
        {1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b1000, 8'd2},  // R11 step
        {1'b1, 4'b1001, 1'b0, 1'b0, 1'b0, 4'b1000, 8'd2},  // R1 field rewrite
        {1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000, 8'd2}   // R11 tag holds
    };
    localparam int REQ [NV] = '{3, 6, 4, 4, 8, 5, 7, 7, 9, 10, 10, 10, 11, 11, 1, 11};

    task automatic chk(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [3:0] d, input logic e);
        @(negedge clk);
        we = w; wd = d; evt = e;
        @(posedge clk);
        #1;
        @(negedge clk);
        we = 1'b0; wd = '0; evt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [TAG_W-1:0] exp_tag;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("irq after reset", 2, 32'(irq), 0);
        chk("pend after reset", 2, 32'(pend), 0);
        chk("tag after reset", 2, 32'(tag), 0);
        chk("rdata after reset", 2, 32'(rd), 0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            @(negedge clk);
            we = v[19]; wd = v[18:15]; evt = v[14];
            @(posedge clk);
            #1;
            chk($sformatf("vec %0d irq", i), REQ[i], 32'(irq), 32'(v[13]));
            chk($sformatf("vec %0d pend", i), REQ[i], 32'(pend), 32'(v[12]));
            chk($sformatf("vec %0d rdata", i), REQ[i], 32'(rd), 32'(v[11:8]));
            chk($sformatf("vec %0d tag", i), REQ[i], 32'(tag), 32'(v[7:0]));
        end
        @(negedge clk);
        we = 1'b0; wd = '0; evt = 1'b0;

        // R11 wrap: run the tag through 255 -> 1, never 0
        step(1'b1, 4'b1000, 1'b0);
        exp_tag = 8'd2;
        for (int k = 0; k < 260; k++) begin
            @(negedge clk);
            evt = 1'b1;
            @(posedge clk);
            #1;
            exp_tag = (exp_tag == 8'hFF) ? 8'd1 : exp_tag + 8'd1;
            chk($sformatf("tag wrap step %0d", k), 11, 32'(tag), 32'(exp_tag));
            if (tag == '0) chk("tag zero", 11, 32'(tag), 32'd1);
        end
        @(negedge clk);
        evt = 1'b0;

        // R4 masked burst then R8 unmask on next edge
        step(1'b1, 4'b0011, 1'b0);
        step(1'b1, 4'b0010, 1'b0);
        chk("masked, cleared irq stays", 5, 32'(irq), 1);
        step(1'b1, 4'b0000, 1'b0);
        chk("unmask drops irq", 7, 32'(irq), 0);
        step(1'b1, 4'b0010, 1'b1);
        chk("masked event irq", 4, 32'(irq), 0);
        chk("masked event pend", 4, 32'(pend), 1);
        @(negedge clk);
        we = 1'b1; wd = 4'b0000;
        @(posedge clk);
        #1;
        chk("unmask asserts next edge", 8, 32'(irq), 1);
        @(negedge clk);
        we = 1'b0;

        // R2 reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("irq after 2nd reset", 2, 32'(irq), 0);
        chk("tag after 2nd reset", 2, 32'(tag), 0);
        chk("rdata after 2nd reset", 2, 32'(rd), 0);
        finish_run();
    end
endmodule